// File: doc/BRIEF.md
# Output Frame CRC Generator

This block builds the byte sequence that a converter returns to its host over a serial link, and appends a check byte to it. At a frame-start pulse it takes a frame kind and the candidate payload: a 16-bit conversion word, a status byte and a register byte. It then lays out two or three data bytes, or register data followed by zero padding. The bytes are offered one at a time to a downstream serializer through a valid/ready handshake, most significant byte first.

The check byte is an 8-bit CRC with generator x^8 + x^2 + x + 1 (0x07). The register is preset to 0xFF at every frame start, and the bytes are fed in most significant bit first, with no final inversion. Every data byte offered before the check byte is covered, pad bytes included. A CRC-enable input, taken at frame start, decides whether the check byte is appended at all. A frame start that arrives while a frame is still going abandons that frame and begins the new one.

Top module: `frame_crc_tx`

## Requirements
- R1: While reset is low, and for the cycles after it is released until the first frame start, out_valid and out_last are 0.
- R2: Kind 0 (frame_kind = 2'b00) offers two data bytes: conv_word[15:8], then conv_word[7:0].
- R3: Kind 1 (frame_kind = 2'b01) offers three data bytes: conv_word[15:8], then conv_word[7:0], then stat_byte.
- R4: Kind 2 (frame_kind = 2'b10) offers two data bytes: reg_byte, then 8'h00.
- R5: Kind 3 (frame_kind = 2'b11) offers three data bytes: reg_byte, then 8'h00, then 8'h00.
- R6: The check byte is the CRC of all data bytes of the frame. The CRC uses generator 0x07 and a 0xFF preset, with bits fed MSB first and no output inversion.
- R7: With crc_en = 1 at frame start, the check byte is offered in the cycle right after the last data byte is accepted, and out_last is set only on the check byte. With crc_en = 0, no check byte follows, and out_last is set on the last data byte. While out_ready stays 1, out_valid has no gap within a frame.
- R8: While out_valid is 1 and out_ready is 0, out_byte and out_last hold their values. A byte is consumed only on a cycle with both signals high.
- R9: frame_start is sampled on the clock edge and is honoured in any state, including mid-frame, where it drops the unfinished frame. frame_kind, crc_en and the payload inputs are captured only on that edge, and changing them later has no effect on the frame.
- R10: After the byte marked out_last is accepted, out_valid is 0 from the next cycle until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Begins a new frame; captures kind, enable and payload |
| frame_kind | input | 2 | Frame layout selector (see R2 to R5) |
| crc_en | input | 1 | Append the check byte when 1 |
| conv_word | input | 16 | Conversion word |
| stat_byte | input | 8 | Status byte for kind 1 |
| reg_byte | input | 8 | Register byte for kinds 2 and 3 |
| out_ready | input | 1 | Serializer can take a byte |
| out_valid | output | 1 | A byte is on out_byte |
| out_byte | output | 8 | Current byte |
| out_last | output | 1 | Current byte ends the frame |

## Verification
The checker watches four things on every cycle: the handshake hold under backpressure, the absence of gaps, the idle state after the closing byte, and the start of output after a frame start. It also checks that the outputs stay quiet while reset is held. Byte order, pad values, CRC values and the choice of the closing byte depend on the captured payload. Only the bench scenarios show these. They sweep every frame kind with the check byte on and off, use many payloads with and without stalls, change the inputs after capture, and abort a frame midway.

// File: rtl/ofcg_pkg.sv
package ofcg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MAX_DATA = 3;
  localparam int unsigned IDX_W    = $clog2(MAX_DATA);

  typedef enum logic [1:0] {
    KIND_CONV      = 2'd0,
    KIND_CONV_STAT = 2'd1,
    KIND_REG_PAD1  = 2'd2,
    KIND_REG_PAD2  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CHK  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/ofcg_frame_map.sv
module ofcg_frame_map
  import ofcg_pkg::*;
#(
  parameter int unsigned BW   = 8,
  parameter int unsigned MAXB = 3,
  localparam int unsigned IW  = $clog2(MAXB)
) (
  input  kind_e                   kind,
  input  logic [2*BW-1:0]         conv_word,
  input  logic [BW-1:0]           stat_byte,
  input  logic [BW-1:0]           reg_byte,
  output logic [MAXB-1:0][BW-1:0] bytes,
  output logic [IW-1:0]           last_idx
);
  // Lays out the data bytes of one frame; unused slots are zero.
  always_comb begin
    bytes    = '0;
    last_idx = IW'(1);
    unique case (kind)
      KIND_CONV: begin
        bytes[0] = conv_word[2*BW-1:BW];
        bytes[1] = conv_word[BW-1:0];
        last_idx = IW'(1);
      end
      KIND_CONV_STAT: begin
        bytes[0] = conv_word[2*BW-1:BW];
        bytes[1] = conv_word[BW-1:0];
        bytes[2] = stat_byte;
        last_idx = IW'(2);
      end
      KIND_REG_PAD1: begin
        bytes[0] = reg_byte;
        last_idx = IW'(1);
      end
      KIND_REG_PAD2: begin
        bytes[0] = reg_byte;
        last_idx = IW'(2);
      end
      default: begin
        bytes    = '0;
        last_idx = IW'(1);
      end
    endcase
  end
endmodule

// File: rtl/ofcg_crc_step.sv
module ofcg_crc_step #(
  parameter int unsigned BW     = 8,
  parameter logic [BW-1:0] POLY = 8'h07
) (
  input  logic [BW-1:0] crc_in,
  input  logic [BW-1:0] data_in,
  output logic [BW-1:0] crc_out
);
  // One full byte of CRC update, unrolled one stage per bit, MSB first.
  logic [BW-1:0] stage [0:BW];

  assign stage[0] = crc_in ^ data_in;

  for (genvar g = 0; g < BW; g++) begin : g_bit
    logic [BW-1:0] shifted;
    assign shifted      = {stage[g][BW-2:0], 1'b0};
    assign stage[g + 1] = stage[g][BW-1] ? (shifted ^ POLY) : shifted;
  end

  assign crc_out = stage[BW];
endmodule

// File: rtl/ofcg_seq.sv
module ofcg_seq
  import ofcg_pkg::*;
#(
  parameter int unsigned BW     = 8,
  parameter int unsigned MAXB   = 3,
  parameter logic [BW-1:0] INIT = 8'hFF,
  localparam int unsigned IW    = $clog2(MAXB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    crc_en,
  input  logic [MAXB-1:0][BW-1:0] bytes_in,
  input  logic [IW-1:0]           last_in,
  input  logic                    out_ready,
  input  logic [BW-1:0]           crc_upd,
  output logic [BW-1:0]           crc_cur,
  output logic [BW-1:0]           data_cur,
  output logic                    out_valid,
  output logic [BW-1:0]           out_byte,
  output logic                    out_last
);
  seq_st_e                 st_q, st_d;
  logic [IW-1:0]           idx_q, idx_d;
  logic [IW-1:0]           last_q;
  logic                    en_q;
  logic [MAXB-1:0][BW-1:0] buf_q;
  logic [BW-1:0]           crc_q, crc_d;
  logic                    fire, at_last, adv_en;

  assign data_cur  = buf_q[idx_q];
  assign crc_cur   = crc_q;
  assign fire      = out_valid && out_ready;
  assign at_last   = (idx_q == last_q);
  assign adv_en    = start || fire;

  assign out_valid = (st_q != ST_IDLE);
  assign out_byte  = (st_q == ST_CHK) ? crc_q : data_cur;
  assign out_last  = (st_q == ST_CHK) || ((st_q == ST_DATA) && at_last && !en_q);

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    crc_d = crc_q;
    if (start) begin
      st_d  = ST_DATA;
      idx_d = '0;
      crc_d = INIT;
    end else if (fire) begin
      unique case (st_q)
        ST_DATA: begin
          crc_d = crc_upd;
          if (at_last) begin
            st_d = en_q ? ST_CHK : ST_IDLE;
          end else begin
            idx_d = idx_q + {{(IW-1){1'b0}}, 1'b1};
          end
        end
        ST_CHK:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Sequencing registers, enabled on start or byte transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      crc_q <= INIT;
    end else if (adv_en) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      crc_q <= crc_d;
    end
  end

  // Frame capture registers, enabled on start only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      en_q   <= 1'b0;
      buf_q  <= '0;
    end else if (start) begin
      last_q <= last_in;
      en_q   <= crc_en;
      buf_q  <= bytes_in;
    end
  end
endmodule

// File: rtl/frame_crc_tx.sv
module frame_crc_tx
  import ofcg_pkg::*;
#(
  parameter int unsigned BW          = BYTE_W,
  parameter int unsigned MAXB        = MAX_DATA,
  parameter logic [BW-1:0] CRC_POLY  = 8'h07,
  parameter logic [BW-1:0] CRC_INIT  = 8'hFF,
  parameter int unsigned RST_STAGES  = 2,
  localparam int unsigned IW         = $clog2(MAXB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [1:0]    frame_kind,
  input  logic          crc_en,
  input  logic [2*BW-1:0] conv_word,
  input  logic [BW-1:0] stat_byte,
  input  logic [BW-1:0] reg_byte,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [BW-1:0] out_byte,
  output logic          out_last
);
  // Reset: asserted asynchronously, released through a synchronizer
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[RST_STAGES-1];

  logic [MAXB-1:0][BW-1:0] map_bytes;
  logic [IW-1:0]           map_last;
  logic [BW-1:0]           crc_cur, crc_upd, data_cur;

  ofcg_frame_map #(.BW(BW), .MAXB(MAXB)) u_map (
    .kind      (kind_e'(frame_kind)),
    .conv_word (conv_word),
    .stat_byte (stat_byte),
    .reg_byte  (reg_byte),
    .bytes     (map_bytes),
    .last_idx  (map_last)
  );

  ofcg_crc_step #(.BW(BW), .POLY(CRC_POLY)) u_crc (
    .crc_in  (crc_cur),
    .data_in (data_cur),
    .crc_out (crc_upd)
  );

  ofcg_seq #(.BW(BW), .MAXB(MAXB), .INIT(CRC_INIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (frame_start),
    .crc_en    (crc_en),
    .bytes_in  (map_bytes),
    .last_in   (map_last),
    .out_ready (out_ready),
    .crc_upd   (crc_upd),
    .crc_cur   (crc_cur),
    .data_cur  (data_cur),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last)
  );
endmodule

// File: rtl/frame_crc_tx_chk.sv
module frame_crc_tx_chk #(
  parameter int unsigned BW = 8
) (
  input logic          clk,
  input logic          arst_n,
  input logic          rst_n,
  input logic          frame_start,
  input logic          out_ready,
  input logic          out_valid,
  input logic [BW-1:0] out_byte,
  input logic          out_last
);
  // R1: quiet outputs while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !arst_n |-> (!out_valid && !out_last));

  // R8: hold under backpressure
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=>
      (out_valid && $stable(out_byte) && $stable(out_last)));

  // R7: no gap inside a frame
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && !frame_start) |=> out_valid);

  // R10: idle after the closing byte
  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !frame_start) |=> !out_valid);

  // R9: a frame start always yields a byte next cycle
  a_r9_start_offers: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (out_valid && !$stable(out_valid) || out_valid));
endmodule

bind frame_crc_tx frame_crc_tx_chk #(.BW(BW)) u_chk (
  .clk         (clk),
  .arst_n      (rst_n),
  .rst_n       (rst_q_n),
  .frame_start (frame_start),
  .out_ready   (out_ready),
  .out_valid   (out_valid),
  .out_byte    (out_byte),
  .out_last    (out_last)
);

// File: tb/frame_crc_tx_bench.sv
module frame_crc_tx_bench;
  logic        clk;
  logic        rst_n;
  logic        frame_start;
  logic [1:0]  frame_kind;
  logic        crc_en;
  logic [15:0] conv_word;
  logic [7:0]  stat_byte;
  logic [7:0]  reg_byte;
  logic        out_ready;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  int wd     = 0;
  bit wd_hit = 0;

  frame_crc_tx u_frame_crc_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_kind(frame_kind),
    .crc_en(crc_en), .conv_word(conv_word), .stat_byte(stat_byte), .reg_byte(reg_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !wd_hit) begin
      wd_hit = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", wd);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bit-serial reference CRC: feedback form, MSB first
  function automatic logic [7:0] ref_crc(input logic [7:0] b [4], input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) begin
        logic fb = c[7] ^ b[i][k];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  task automatic run_frame(input logic [1:0] k, input logic en, input logic [15:0] cw,
                           input logic [7:0] sb, input logic [7:0] rb, input bit stall);
    logic [7:0] exp [4];
    int n, got, cyc;
    bit done, held;
    logic [7:0] held_byte;
    string req;
    exp = '{default: 8'h00};
    case (k)
      2'd0: begin exp[0] = cw[15:8]; exp[1] = cw[7:0]; n = 2; req = "R2"; end
      2'd1: begin exp[0] = cw[15:8]; exp[1] = cw[7:0]; exp[2] = sb; n = 3; req = "R3"; end
      2'd2: begin exp[0] = rb; exp[1] = 8'h00; n = 2; req = "R4"; end
      default: begin exp[0] = rb; exp[1] = 8'h00; exp[2] = 8'h00; n = 3; req = "R5"; end
    endcase
    if (en) begin exp[n] = ref_crc(exp, n); n++; end

    @(negedge clk);
    frame_kind = k; crc_en = en; conv_word = cw; stat_byte = sb; reg_byte = rb;
    frame_start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    // R9: inputs changed after capture must not matter
    frame_kind = ~k; crc_en = ~en; conv_word = ~cw; stat_byte = ~sb; reg_byte = ~rb;
    got = 0; cyc = 0; done = 0; held = 0; held_byte = '0;
    while (!done && cyc < 40) begin
      out_ready = stall ? cyc[0] : 1'b1;
      if (held) begin
        chk(out_valid && out_byte == held_byte, "R8", "stalled byte held", out_byte, held_byte);
        held = 0;
      end
      if (out_valid && out_ready) begin
        chk(out_byte == exp[got], (en && got == n - 1) ? "R6" : req, "byte value",
            out_byte, exp[got]);
        chk(out_last == (got == n - 1), "R7", "last flag", out_last, got == n - 1);
        got++;
        if (out_last) done = 1;
      end else if (out_valid) begin
        held = 1; held_byte = out_byte;
      end else if (!stall) begin
        chk(0, "R7", "gap inside frame", 0, 1);
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(got == n, "R7", "bytes in frame", got, n);
    chk(!out_valid, "R10", "idle after last", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; frame_kind = 2'd0; crc_en = 1'b0;
    conv_word = '0; stat_byte = '0; reg_byte = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_last, "R1", "outputs in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_last, "R1", "outputs after release", out_valid, 0);

    // Sweep: every kind, enable on/off, many payloads, with and without stalls
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++)
        for (int e = 0; e < 2; e++)
          run_frame(2'(k), e[0], 16'(p * 16'h9E37) ^ 16'(p == 15 ? 16'hFFFF : 0),
                    8'(p * 37 + 5), 8'(p == 15 ? 8'hFF : p * 73), p[0]);

    // Abort mid-frame (R9): start kind 3, take one byte, restart with kind 1
    @(negedge clk);
    frame_kind = 2'd3; crc_en = 1'b1; reg_byte = 8'hA5; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid, "R9", "mid-frame before abort", out_valid, 1);
    run_frame(2'd1, 1'b1, 16'h1234, 8'h5A, 8'h00, 1'b0);
    run_frame(2'd0, 1'b1, 16'h0000, 8'h00, 8'h00, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule